// File: doc/BRIEF.md
# Progressive Arrow Warning Sign Sequencer

This block sequences the lamps of an arrow-shaped road warning sign. While an operator switch is held on, the lamps light up in a growing pattern: first dark, then the first lamp pair, then the first two pairs, then all five lamps. The pattern then starts again from dark and repeats for as long as the switch stays on. When the switch is turned off, the sign goes dark and stays dark.

The sequencer holds two bits of state, and the lamp drives depend only on that state. A rate divider thins the incoming step-enable strobe into a slow tick, so each pattern step stays visible. Every state change, including the return to dark after switch-off, takes effect only on a tick. The asynchronous switch passes through a two-flop synchroniser before the state logic sees it. The block drives three lamp-group outputs and a five-line per-lamp vector, all from registers.

Top module: `warn_sign_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state returns to dark and the rate divider restarts from zero. After that edge all lamp outputs read 0. After reset is released, the first tick comes on the DIV-th cycle that has `step_en` high.
- R2: With the synchronised switch at 1, each tick moves the state one step through the order 00, 01, 10, 11, and from 11 back to 00.
- R3: With the synchronised switch at 0, a tick puts the state at 00, whatever the current state.
- R4: The state changes only on a tick. A tick is the cycle in which `step_en` is high and the divider count equals DIV-1, and it returns the count to 0.
- R5: A cycle with `step_en` low leaves the divider count unchanged, so it neither produces a tick nor brings the next one closer.
- R6: Group decode from state (z,y,x): 00 gives 0,0,0; 01 gives 1,0,0; 10 gives 1,1,0; 11 gives 1,1,1.
- R7: `lamp[4:0]` equals {x, y, y, z, z}. Bit 0 and bit 1 are lamps 1 and 2 (group z), bits 2 and 3 are lamps 3 and 4 (group y), and bit 4 is lamp 5 (group x).
- R8: `sw_in` reaches the state logic through two flip-flops. A tick sees the switch value that was sampled two edges before it.
- R9: The outputs are registered. After each edge they show the decode of the state that was held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | 1 | Operator switch, asynchronous, 1 = run |
| step_en | input | 1 | Step strobe counted by the rate divider |
| grp_z | output | 1 | Drive for lamps 1 and 2 |
| grp_y | output | 1 | Drive for lamps 3 and 4 |
| grp_x | output | 1 | Drive for lamp 5 |
| lamp | output | 5 | Per-lamp drives, bit 0 = lamp 1 through bit 4 = lamp 5 |

## Verification
The bench aims at the wrap from the all-on state back to dark. A design that saturates there, or that skips a state, breaks the cycle of four ticks. Switch-off is checked in every state and in the middle of a divider period: a design that goes dark at once instead of on the next tick, or that skips the synchroniser delay, gets the timing of the drop wrong. Gaps in `step_en` check that the divider stalls; a design that keeps counting in those cycles would tick early. A reset in mid-run checks that both the state and the divider phase restart, and the five-line vector is compared on every cycle against its group wiring.

// File: rtl/warn_sign_pkg.sv
`timescale 1ns/1ps
package warn_sign_pkg;

  typedef enum logic [1:0] {
    ST_DARK = 2'b00,
    ST_Z    = 2'b01,
    ST_ZY   = 2'b10,
    ST_ZYX  = 2'b11
  } sign_state_t;

  typedef struct packed {
    logic x;
    logic y;
    logic z;
  } grp_t;

  typedef enum logic [1:0] {
    SRC_Z = 2'd0,
    SRC_Y = 2'd1,
    SRC_X = 2'd2
  } grp_src_t;

  localparam int LAMP_N = 5;

  // Which group feeds lamp line idx (0 = lamp 1)
  function automatic grp_src_t lamp_src(input int idx);
    if (idx < 2)      return SRC_Z;
    else if (idx < 4) return SRC_Y;
    else              return SRC_X;
  endfunction

  function automatic grp_t decode_grp(input sign_state_t st);
    grp_t g;
    unique case (st)
      ST_DARK: g = '{x: 1'b0, y: 1'b0, z: 1'b0};
      ST_Z:    g = '{x: 1'b0, y: 1'b0, z: 1'b1};
      ST_ZY:   g = '{x: 1'b0, y: 1'b1, z: 1'b1};
      default: g = '{x: 1'b1, y: 1'b1, z: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/ws_sync.sv
`timescale 1ns/1ps
module ws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (chain_q[1] == $past(chain_q[0])));
endmodule

// File: rtl/ws_rate_div.sv
`timescale 1ns/1ps
module ws_rate_div #(
  parameter int DIV = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = step_en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else if (step_en) cnt_q <= cnt_q + 1'b1;
  end

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(cnt_q));
  // R4
  div_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
  // R1
  div_clear_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/ws_seq_fsm.sv
`timescale 1ns/1ps
module ws_seq_fsm
  import warn_sign_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        sw,
  output sign_state_t state
);
  sign_state_t state_q;
  sign_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (tick) state_d = sw ? sign_state_t'(state_q + 2'd1) : ST_DARK;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_DARK;
    else     state_q <= state_d;
  end

  assign state = state_q;

  // R1
  fsm_reset_chk: assert property (@(posedge clk)
    rst |=> (state_q == ST_DARK));
  // R3
  fsm_off_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !sw) |=> (state_q == ST_DARK));
  // R2
  fsm_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sw) |=> (state_q == sign_state_t'($past(state_q) + 2'd1)));
  // R4
  fsm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(state_q));
endmodule

// File: rtl/ws_lamp_decode.sv
`timescale 1ns/1ps
module ws_lamp_decode
  import warn_sign_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  sign_state_t       state,
  output logic              grp_z,
  output logic              grp_y,
  output logic              grp_x,
  output logic [LAMP_N-1:0] lamp
);
  grp_t              grp_c;
  grp_t              grp_q;
  logic [LAMP_N-1:0] lamp_c;
  logic [LAMP_N-1:0] lamp_q;

  assign grp_c = decode_grp(state);

  for (genvar i = 0; i < LAMP_N; i++) begin : g_lamp
    localparam grp_src_t SRC = lamp_src(i);
    if (SRC == SRC_Z) begin : g_z
      assign lamp_c[i] = grp_c.z;
    end else if (SRC == SRC_Y) begin : g_y
      assign lamp_c[i] = grp_c.y;
    end else begin : g_x
      assign lamp_c[i] = grp_c.x;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q  <= '0;
      lamp_q <= '0;
    end else begin
      grp_q  <= grp_c;
      lamp_q <= lamp_c;
    end
  end

  assign grp_z = grp_q.z;
  assign grp_y = grp_q.y;
  assign grp_x = grp_q.x;
  assign lamp  = lamp_q;

  // R6
  grp_thermo_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_q.x |-> grp_q.y) and (grp_q.y |-> grp_q.z));
  // R9
  out_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DARK) |=> (grp_q == '0));
  // R9
  out_full_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ZYX) |=> grp_q.x);
  // R7
  lamp_map_chk: assert property (@(posedge clk) disable iff (rst)
    lamp_q == {grp_q.x, grp_q.y, grp_q.y, grp_q.z, grp_q.z});
endmodule

// File: rtl/warn_sign_seq.sv
`timescale 1ns/1ps
module warn_sign_seq
  import warn_sign_pkg::*;
#(
  parameter int DIV         = 12_500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_in,
  input  logic       step_en,
  output logic       grp_z,
  output logic       grp_y,
  output logic       grp_x,
  output logic [4:0] lamp
);
  logic        sw_s;
  logic        tick;
  sign_state_t state;

  ws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sw_in),
    .q   (sw_s)
  );

  ws_rate_div #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .tick    (tick)
  );

  ws_seq_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .sw    (sw_s),
    .state (state)
  );

  ws_lamp_decode u_dec (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .grp_z (grp_z),
    .grp_y (grp_y),
    .grp_x (grp_x),
    .lamp  (lamp)
  );
endmodule

// File: tb/warn_sign_seq_tb.sv
`timescale 1ns/1ps
module warn_sign_seq_tb;
  localparam int DIV = 3;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_in = 1'b0;
  logic       step_en = 1'b0;
  logic       grp_z, grp_y, grp_x;
  logic [4:0] lamp;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_tag = "R1";

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // reference model state, built from the requirements
  logic m_s1 = 1'b0, m_s2 = 1'b0;
  int   m_cnt = 0;
  int   m_state = 0;

  always #10 clk = ~clk;

  warn_sign_seq #(.DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .sw_in(sw_in), .step_en(step_en),
    .grp_z(grp_z), .grp_y(grp_y), .grp_x(grp_x), .lamp(lamp)
  );

  // R6 table: state -> {x,y,z}; R7 vector {x,y,y,z,z}
  function automatic logic [7:0] expect_of(input int st);
    logic [2:0] g;
    case (st)
      0: g = 3'b000;
      1: g = 3'b001;
      2: g = 3'b011;
      default: g = 3'b111;
    endcase
    return {g, g[2], g[1], g[1], g[0], g[0]};
  endfunction

  // driver side of the scoreboard: predict the registered outputs
  always @(posedge clk) begin
    logic tick;
    cycles++;
    if (rst) begin
      exp_q.push_back(8'h00);
      m_state = 0; m_cnt = 0; m_s1 = 1'b0; m_s2 = 1'b0;
    end else begin
      exp_q.push_back(expect_of(m_state));          // R9: old state shows
      tick = step_en && (m_cnt == DIV - 1);         // R4
      if (tick) m_state = m_s2 ? (m_state + 1) % 4 : 0; // R2 R3
      if (tick) m_cnt = 0;
      else if (step_en) m_cnt = m_cnt + 1;          // R5
      m_s2 = m_s1;                                   // R8
      m_s1 = sw_in;
    end
    tag_q.push_back(cur_tag);
  end

  // monitor side: compare away from the active edge
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({grp_x, grp_y, grp_z} !== e[7:5]) begin
        failures++;
        $display("FAIL %s groups xyz actual=%b expected=%b t=%0t", t,
                 {grp_x, grp_y, grp_z}, e[7:5], $time);
      end
      checks++;
      if (lamp !== e[4:0]) begin
        failures++;
        $display("FAIL %s R7 lamp actual=%b expected=%b t=%0t", t, lamp, e[4:0], $time);
      end
      checks++;
      if (lamp !== {grp_x, grp_y, grp_y, grp_z, grp_z}) begin
        failures++;
        $display("FAIL R7 lamp wiring actual=%b expected=%b", lamp,
                 {grp_x, grp_y, grp_y, grp_z, grp_z});
      end
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    cur_tag = "R1"; rst = 1'b1; run(4);
    // R2 R4 R6 R8 R9: continuous stepping, several wraps
    @(negedge clk); rst = 1'b0; sw_in = 1'b1; step_en = 1'b1;
    cur_tag = "R2 R4"; run(40);
    // R3 R8: switch off mid-divider from various states
    for (int k = 0; k < 4; k++) begin
      cur_tag = "R2 R6"; sw_in = 1'b1; run(3 * DIV * (k + 1) + 1);
      cur_tag = "R3 R8"; sw_in = 1'b0; run(2 * DIV + 3);
    end
    // R5: sparse step strobes
    cur_tag = "R5"; sw_in = 1'b1;
    for (int i = 0; i < 60; i++) begin
      step_en = (i % 3 != 1) && (i % 7 != 0);
      @(negedge clk);
    end
    step_en = 1'b1;
    // R1: reset mid-run, divider phase restarts
    cur_tag = "R2"; run(5);
    cur_tag = "R1"; rst = 1'b1; run(2);
    rst = 1'b0; cur_tag = "R1 R4"; run(30);
    // short switch pulse caught by synchroniser (R8)
    cur_tag = "R8"; sw_in = 1'b0; run(8);
    sw_in = 1'b1; @(negedge clk); sw_in = 1'b0; run(12);
    run(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles >= WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule